// File: doc/BRIEF.md
# SPI Display Register Access Engine

This block is a hardware SPI master that performs register accesses on a serially attached display controller in place of driver software. A client presents one command at a time: an index write, a register write, a register read or a status read. Each command carries an 8-bit register offset and a 16-bit write value. The engine builds the coded start byte and the byte sequence for that command, and runs each phase in its own chip-select frame. For reads it returns a 16-bit result. A one-cycle `done` pulse marks the end of the command, and `busy` covers the command from acceptance to completion.

Each frame begins with a start byte. Its upper five bits are fixed, and its three low bits give a device identifier bit, an index/register select and a read/write flag. A register access is split into two frames: the first loads the index and the second moves the value. A status read is one longer frame whose first returned data byte is a dummy to be discarded. When a configuration input asks for it, each transmitted byte can be complemented on the line. The serial clock for these accesses is derived from the system clock by a divider. The divider's ratio is computed from the system frequency and a register-access ceiling of 4 MHz.

Top module: `spi_reg_engine`

## Requirements
- R1: Every frame begins with the start byte {5'b01110, id, rs, rw}, where id is `dev_id` sampled at command acceptance. rs=0 selects the index register and rs=1 a register. rw=0 is a write and rw=1 a read. `cmd_op` encodes 0 = index write, 1 = register write, 2 = register read, 3 = status read.
- R2: An index write (op 0) produces exactly one 3-byte frame: start(rs=0,rw=0), 0x00, then the offset.
- R3: A register write (op 1) produces the index frame of R2, then a second 3-byte frame: start(rs=1,rw=0), value high byte, value low byte. Chip-select stays high between the two frames for at least one full SCLK period.
- R4: A register read (op 2) produces the index frame of R2, then a 3-byte frame: start(rs=1,rw=1), 0x00, 0x00. `rdata` becomes {second received byte, third received byte} of that frame.
- R5: A status read (op 3) produces exactly one 4-byte frame: start(rs=0,rw=1) followed by three 0x00 bytes. `rdata` becomes {third received byte, fourth received byte}. The second received byte has no effect on `rdata`.
- R6: When `tx_invert` is 1 at acceptance, every transmitted byte (the start byte included) appears on MOSI bitwise complemented. Received data is not inverted.
- R7: Bytes are shifted MSB first in SPI mode 0. SCLK idles low. MOSI changes only while SCLK is low, and MISO is sampled on the SCLK rising edge. SCLK is never high while chip-select is deasserted (high).
- R8: Each SCLK high and low phase lasts at least HALF_DIV = ceil(SYS_HZ / (2*REG_SCLK_HZ)) system cycles, so the SCLK period in cycles times REG_SCLK_HZ is at least SYS_HZ.
- R9: A command is accepted when `cmd_valid` is high and `busy` is low. `busy` is high from the cycle after acceptance until `done`. A `cmd_valid` while busy is ignored and starts no frame.
- R10: `done` is high for exactly one cycle after the last frame of a command ends, with `busy` low in that cycle. `rdata` holds the read result at `done`. Write commands leave `rdata` unchanged.
- R11: After reset, chip-select is high, SCLK is low, `busy` and `done` are low, and `rdata` is zero.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous active-high reset |
| cmd_valid | input | 1 | Command request, taken when busy is low |
| cmd_op | input | 2 | Command kind (0 index wr, 1 reg wr, 2 reg rd, 3 status rd) |
| cmd_reg | input | 8 | Register offset |
| cmd_wdata | input | 16 | Value for a register write |
| dev_id | input | 1 | Device identifier bit placed in the start byte |
| tx_invert | input | 1 | Complement every transmitted byte when high |
| busy | output | 1 | Command in progress |
| done | output | 1 | One-cycle completion pulse |
| rdata | output | 16 | Result of the last read command |
| spi_sclk | output | 1 | Serial clock, idle low |
| spi_mosi | output | 1 | Serial data to the display |
| spi_cs_n | output | 1 | Active-low chip-select |
| spi_miso | input | 1 | Serial data from the display |

## Verification
The embedded properties assume that `rst` is held for at least one clock before any command is issued. They also assume that `spi_miso` carries a defined level whenever chip-select is low. The bench slave model holds MISO steady through each SCLK rising edge by changing it only after falling edges. The bench drives commands one cycle wide, away from the clock edge. It deliberately asserts `cmd_valid` during a busy interval, but only to confirm that the request is dropped.

// File: rtl/spi_reg_pkg.sv
package spi_reg_pkg;

    typedef enum logic [1:0] {
        OP_IDX_WR  = 2'd0,
        OP_REG_WR  = 2'd1,
        OP_REG_RD  = 2'd2,
        OP_STAT_RD = 2'd3
    } op_e;

    // One serial frame: up to four bytes, left aligned, MSB sent first.
    typedef struct packed {
        logic [31:0] data;
        logic        four;   // 1: four bytes, 0: three bytes
    } frame_t;

    function automatic logic [7:0] start_code(logic id, logic rs, logic rw);
        return {5'b01110, id, rs, rw};
    endfunction

    function automatic logic [7:0] line_byte(logic [7:0] b, logic inv);
        return inv ? ~b : b;
    endfunction

    function automatic frame_t make_frame(logic [7:0] b0, logic [7:0] b1,
                                          logic [7:0] b2, logic [7:0] b3,
                                          logic four, logic inv);
        frame_t f;
        f.data = {line_byte(b0, inv), line_byte(b1, inv),
                  line_byte(b2, inv), four ? line_byte(b3, inv) : 8'h00};
        f.four = four;
        return f;
    endfunction

endpackage

// File: rtl/spi_frame_shifter.sv
module spi_frame_shifter
    import spi_reg_pkg::*;
#(
    parameter int HALF_DIV = 32
) (
    input  logic        clk,
    input  logic        rst,
    input  logic        start,
    input  frame_t      frm,
    input  logic        miso,
    output logic        sclk,
    output logic        mosi,
    output logic        cs_n,
    output logic        done,
    output logic [31:0] rx
);
    localparam int DW = $clog2(2 * HALF_DIV + 1);
    localparam logic [DW-1:0] HALF_LAST = DW'(HALF_DIV - 1);
    localparam logic [DW-1:0] GAP_LAST  = DW'(2 * HALF_DIV - 1);

    typedef enum logic [1:0] {S_IDLE, S_SHIFT, S_GAP} sh_state_e;

    sh_state_e   st;
    logic [DW-1:0] div;
    logic [5:0]  bitn;
    logic [31:0] txs;
    logic        four_q;
    logic [5:0]  last_bit;

    assign last_bit = four_q ? 6'd31 : 6'd23;

    always_ff @(posedge clk) begin
        if (rst) begin
            st     <= S_IDLE;
            cs_n   <= 1'b1;
            sclk   <= 1'b0;
            mosi   <= 1'b0;
            done   <= 1'b0;
            div    <= '0;
            bitn   <= '0;
            txs    <= '0;
            four_q <= 1'b0;
            rx     <= '0;
        end else begin
            done <= 1'b0;
            case (st)
                S_IDLE: begin
                    if (start) begin
                        txs    <= frm.data;
                        mosi   <= frm.data[31];
                        four_q <= frm.four;
                        cs_n   <= 1'b0;
                        div    <= '0;
                        bitn   <= '0;
                        st     <= S_SHIFT;
                    end
                end
                S_SHIFT: begin
                    if (div == HALF_LAST) begin
                        div <= '0;
                        if (!sclk) begin
                            sclk <= 1'b1;
                            rx   <= {rx[30:0], miso};
                        end else begin
                            sclk <= 1'b0;
                            if (bitn == last_bit) begin
                                cs_n <= 1'b1;
                                mosi <= 1'b0;
                                st   <= S_GAP;
                            end else begin
                                bitn <= bitn + 6'd1;
                                txs  <= {txs[30:0], 1'b0};
                                mosi <= txs[30];
                            end
                        end
                    end else begin
                        div <= div + 1'b1;
                    end
                end
                default: begin
                    if (div == GAP_LAST) begin
                        div  <= '0;
                        done <= 1'b1;
                        st   <= S_IDLE;
                    end else begin
                        div <= div + 1'b1;
                    end
                end
            endcase
        end
    end

    // Phase-length checker for the clock ceiling.
    logic          sclk_q;
    logic [DW-1:0] ph;
    always_ff @(posedge clk) begin
        if (rst) begin
            sclk_q <= 1'b0;
            ph     <= '0;
        end else begin
            sclk_q <= sclk;
            if (sclk != sclk_q)          ph <= DW'(1);
            else if (ph < DW'(HALF_DIV)) ph <= ph + 1'b1;
        end
    end

    assert_phase_len_R8: assert property (@(posedge clk) disable iff (rst)
        (sclk != sclk_q) |-> (ph >= DW'(HALF_DIV)));

    assert_clk_inside_frame_R7: assert property (@(posedge clk) disable iff (rst)
        sclk |-> !cs_n);

    assert_mosi_hold_high_R7: assert property (@(posedge clk) disable iff (rst)
        (sclk && $past(sclk)) |-> $stable(mosi));

endmodule

// File: rtl/spi_reg_sequencer.sv
module spi_reg_sequencer
    import spi_reg_pkg::*;
(
    input  logic        clk,
    input  logic        rst,
    input  logic        cmd_valid,
    input  logic [1:0]  cmd_op,
    input  logic [7:0]  cmd_reg,
    input  logic [15:0] cmd_wdata,
    input  logic        dev_id,
    input  logic        tx_invert,
    input  logic        frame_done,
    input  logic [31:0] rx,
    output logic        frame_start,
    output frame_t      frm,
    output logic        busy,
    output logic        done,
    output logic [15:0] rdata
);
    typedef enum logic [1:0] {Q_IDLE, Q_FIRST, Q_SECOND} seq_state_e;

    seq_state_e  st;
    op_e         op_q;
    logic [7:0]  reg_q;
    logic [15:0] wd_q;
    logic        id_q;
    logic        inv_q;
    logic        accept;

    assign accept = cmd_valid && !busy;

    function automatic frame_t first_frame(op_e op, logic [7:0] rg, logic id, logic inv);
        if (op == OP_STAT_RD)
            return make_frame(start_code(id, 1'b0, 1'b1), 8'h00, 8'h00, 8'h00, 1'b1, inv);
        return make_frame(start_code(id, 1'b0, 1'b0), 8'h00, rg, 8'h00, 1'b0, inv);
    endfunction

    function automatic frame_t second_frame(op_e op, logic [15:0] wd, logic id, logic inv);
        if (op == OP_REG_RD)
            return make_frame(start_code(id, 1'b1, 1'b1), 8'h00, 8'h00, 8'h00, 1'b0, inv);
        return make_frame(start_code(id, 1'b1, 1'b0), wd[15:8], wd[7:0], 8'h00, 1'b0, inv);
    endfunction

    always_ff @(posedge clk) begin
        if (rst) begin
            st          <= Q_IDLE;
            op_q        <= OP_IDX_WR;
            reg_q       <= '0;
            wd_q        <= '0;
            id_q        <= 1'b0;
            inv_q       <= 1'b0;
            frame_start <= 1'b0;
            frm         <= '0;
            busy        <= 1'b0;
            done        <= 1'b0;
            rdata       <= '0;
        end else begin
            frame_start <= 1'b0;
            done        <= 1'b0;
            case (st)
                Q_IDLE: begin
                    if (accept) begin
                        op_q        <= op_e'(cmd_op);
                        reg_q       <= cmd_reg;
                        wd_q        <= cmd_wdata;
                        id_q        <= dev_id;
                        inv_q       <= tx_invert;
                        frm         <= first_frame(op_e'(cmd_op), cmd_reg, dev_id, tx_invert);
                        frame_start <= 1'b1;
                        busy        <= 1'b1;
                        st          <= Q_FIRST;
                    end
                end
                Q_FIRST: begin
                    if (frame_done) begin
                        if (op_q == OP_IDX_WR || op_q == OP_STAT_RD) begin
                            if (op_q == OP_STAT_RD) rdata <= rx[15:0];
                            busy <= 1'b0;
                            done <= 1'b1;
                            st   <= Q_IDLE;
                        end else begin
                            frm         <= second_frame(op_q, wd_q, id_q, inv_q);
                            frame_start <= 1'b1;
                            st          <= Q_SECOND;
                        end
                    end
                end
                default: begin
                    if (frame_done) begin
                        if (op_q == OP_REG_RD) rdata <= rx[15:0];
                        busy <= 1'b0;
                        done <= 1'b1;
                        st   <= Q_IDLE;
                    end
                end
            endcase
        end
    end

    assert_accept_sets_busy_R9: assert property (@(posedge clk) disable iff (rst)
        (cmd_valid && !busy) |=> busy);

    assert_done_single_R10: assert property (@(posedge clk) disable iff (rst)
        done |=> !done);

    assert_done_idle_R10: assert property (@(posedge clk) disable iff (rst)
        done |-> !busy);

    assert_one_frame_index_R2: assert property (@(posedge clk) disable iff (rst)
        (frame_done && st == Q_FIRST && op_q == OP_IDX_WR) |=> (done && !frame_start));

    assert_rdata_kept_on_write_R10: assert property (@(posedge clk) disable iff (rst)
        (done && (op_q == OP_IDX_WR || op_q == OP_REG_WR)) |-> $stable(rdata));

endmodule

// File: rtl/spi_reg_engine.sv
module spi_reg_engine
    import spi_reg_pkg::*;
#(
    parameter int SYS_HZ      = 250_000_000,
    parameter int REG_SCLK_HZ = 4_000_000
) (
    input  logic        clk,
    input  logic        rst,
    input  logic        cmd_valid,
    input  logic [1:0]  cmd_op,
    input  logic [7:0]  cmd_reg,
    input  logic [15:0] cmd_wdata,
    input  logic        dev_id,
    input  logic        tx_invert,
    output logic        busy,
    output logic        done,
    output logic [15:0] rdata,
    output logic        spi_sclk,
    output logic        spi_mosi,
    output logic        spi_cs_n,
    input  logic        spi_miso
);
    localparam int HALF_RAW = (SYS_HZ + 2 * REG_SCLK_HZ - 1) / (2 * REG_SCLK_HZ);
    localparam int HALF_DIV = (HALF_RAW < 1) ? 1 : HALF_RAW;

    logic        frame_start;
    logic        frame_done;
    frame_t      frm;
    logic [31:0] rx;

    spi_reg_sequencer u_seq (
        .clk         (clk),
        .rst         (rst),
        .cmd_valid   (cmd_valid),
        .cmd_op      (cmd_op),
        .cmd_reg     (cmd_reg),
        .cmd_wdata   (cmd_wdata),
        .dev_id      (dev_id),
        .tx_invert   (tx_invert),
        .frame_done  (frame_done),
        .rx          (rx),
        .frame_start (frame_start),
        .frm         (frm),
        .busy        (busy),
        .done        (done),
        .rdata       (rdata)
    );

    spi_frame_shifter #(.HALF_DIV(HALF_DIV)) u_shift (
        .clk   (clk),
        .rst   (rst),
        .start (frame_start),
        .frm   (frm),
        .miso  (spi_miso),
        .sclk  (spi_sclk),
        .mosi  (spi_mosi),
        .cs_n  (spi_cs_n),
        .done  (frame_done),
        .rx    (rx)
    );

    assert_idle_no_frame_R9: assert property (@(posedge clk) disable iff (rst)
        (!busy && !done) |=> spi_cs_n);

endmodule

// File: tb/spi_reg_engine_bench.sv
module spi_reg_engine_bench;

    localparam int SYS_HZ = 250_000_000;
    localparam int REG_HZ = 4_000_000;
    localparam int NVEC   = 10;

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        cmd_valid = 1'b0;
    logic [1:0]  cmd_op = '0;
    logic [7:0]  cmd_reg = '0;
    logic [15:0] cmd_wdata = '0;
    logic        dev_id = 1'b1;
    logic        tx_invert = 1'b0;
    logic        busy, done;
    logic [15:0] rdata;
    logic        spi_sclk, spi_mosi, spi_cs_n, spi_miso;

    always #2 clk = ~clk;

    spi_reg_engine #(.SYS_HZ(SYS_HZ), .REG_SCLK_HZ(REG_HZ)) u_spi_reg_engine (
        .clk(clk), .rst(rst), .cmd_valid(cmd_valid), .cmd_op(cmd_op),
        .cmd_reg(cmd_reg), .cmd_wdata(cmd_wdata), .dev_id(dev_id),
        .tx_invert(tx_invert), .busy(busy), .done(done), .rdata(rdata),
        .spi_sclk(spi_sclk), .spi_mosi(spi_mosi), .spi_cs_n(spi_cs_n),
        .spi_miso(spi_miso)
    );

    int tests = 0;
    int fails = 0;

    task automatic check(string req, logic [31:0] act, logic [31:0] exp);
        tests++;
        if (act !== exp) begin
            fails++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    // ---------------- slave model ----------------
    logic [31:0] resp = '0;
    int          fcnt = 0;
    always @(negedge spi_sclk or posedge spi_cs_n)
        if (spi_cs_n) fcnt = 0; else fcnt = fcnt + 1;
    assign spi_miso = (!spi_cs_n && fcnt < 32) ? resp[31 - fcnt] : 1'b0;

    logic [31:0] fr_data [0:7];
    int          fr_len  [0:7];
    int          nfr = 0;
    logic [31:0] rbuf = '0;
    int          rbits = 0;
    always @(posedge spi_sclk or posedge spi_cs_n) begin
        if (spi_cs_n) begin
            if (rbits > 0) begin
                fr_data[nfr % 8] = (rbits == 24) ? {rbuf[23:0], 8'h00} : rbuf;
                fr_len[nfr % 8]  = rbits / 8;
                nfr = nfr + 1;
            end
            rbits = 0;
            rbuf  = '0;
        end else begin
            rbuf  = {rbuf[30:0], spi_mosi};
            rbits = rbits + 1;
        end
    end

    // ---------------- line monitors ----------------
    longint cyc = 0, last_rise = -1, cs_rise = -1;
    longint min_per = 1000000, min_gap = 1000000;
    int     mode_viol = 0;
    logic   p_sclk = 1'b0, p_mosi = 1'b0, p_cs = 1'b1;
    always @(negedge clk) begin
        cyc++;
        if (!rst) begin
            if (spi_sclk && !p_sclk) begin
                if (last_rise >= 0 && cyc - last_rise < min_per) min_per = cyc - last_rise;
                last_rise = cyc;
            end
            if (spi_cs_n && !p_cs) begin
                cs_rise = cyc;
                last_rise = -1;
            end
            if (!spi_cs_n && p_cs && cs_rise >= 0 && cyc - cs_rise < min_gap)
                min_gap = cyc - cs_rise;
            if (p_sclk && spi_sclk && spi_mosi !== p_mosi) mode_viol++;
            if (spi_cs_n && spi_sclk) mode_viol++;
        end
        p_sclk = spi_sclk; p_mosi = spi_mosi; p_cs = spi_cs_n;
    end

    // ---------------- expected-frame model ----------------
    function automatic logic [7:0] ob(logic [7:0] b, logic inv);
        return inv ? ~b : b;
    endfunction
    function automatic logic [7:0] sb(logic id, logic rs, logic rw);
        return {5'b01110, id, rs, rw};
    endfunction

    // vector: op(2) reg(8) wdata(16) inv(1) id(1) resp(32)
    localparam logic [59:0] VEC [0:NVEC-1] = '{
        {2'd0, 8'h22, 16'h0000, 1'b0, 1'b1, 32'h0000_0000},
        {2'd1, 8'h10, 16'h4240, 1'b0, 1'b1, 32'h0000_0000},
        {2'd2, 8'h00, 16'h0000, 1'b0, 1'b1, 32'hA592_2100},
        {2'd3, 8'h00, 16'h0000, 1'b0, 1'b1, 32'h5AFF_1234},
        {2'd1, 8'h13, 16'h1319, 1'b1, 1'b1, 32'hFFFF_FFFF},
        {2'd2, 8'h45, 16'h0000, 1'b1, 1'b0, 32'h00DB_0000},
        {2'd3, 8'h00, 16'h0000, 1'b1, 1'b0, 32'h0000_8001},
        {2'd0, 8'hFF, 16'h0000, 1'b1, 1'b0, 32'hFFFF_FFFF},
        {2'd1, 8'h01, 16'h691B, 1'b0, 1'b0, 32'h1234_5678},
        {2'd2, 8'hC3, 16'h0000, 1'b0, 1'b0, 32'h8000_0100}
    };

    logic [15:0] exp_rdata = 16'h0000;

    task automatic wait_done(output bit ok);
        ok = 0;
        for (int i = 0; i < 20000; i++) begin
            @(negedge clk);
            if (done) begin ok = 1; break; end
        end
    endtask

    task automatic issue(logic [1:0] op, logic [7:0] rg, logic [15:0] wd,
                         logic inv, logic id);
        @(negedge clk);
        cmd_op = op; cmd_reg = rg; cmd_wdata = wd; tx_invert = inv; dev_id = id;
        cmd_valid = 1'b1;
        @(negedge clk);
        cmd_valid = 1'b0;
        check("R9 busy after accept", {31'd0, busy}, 32'd1);
    endtask

    task automatic run_cmd(logic [1:0] op, logic [7:0] rg, logic [15:0] wd,
                           logic inv, logic id, logic [31:0] rs);
        int base, nexp;
        bit ok;
        logic [31:0] e0, e1;
        string tg;
        resp = rs;
        base = nfr;
        tg = inv ? "R6" : (op == 0 ? "R2" : op == 1 ? "R3" : op == 2 ? "R4" : "R5");
        if (op == 2'd3) begin
            e0 = {ob(sb(id, 1'b0, 1'b1), inv), ob(8'h00, inv), ob(8'h00, inv), ob(8'h00, inv)};
            nexp = 1;
        end else begin
            e0 = {ob(sb(id, 1'b0, 1'b0), inv), ob(8'h00, inv), ob(rg, inv), 8'h00};
            nexp = (op == 2'd0) ? 1 : 2;
        end
        if (op == 2'd2) e1 = {ob(sb(id, 1'b1, 1'b1), inv), ob(8'h00, inv), ob(8'h00, inv), 8'h00};
        else            e1 = {ob(sb(id, 1'b1, 1'b0), inv), ob(wd[15:8], inv), ob(wd[7:0], inv), 8'h00};
        issue(op, rg, wd, inv, id);
        wait_done(ok);
        check({tg, " R10 done seen"}, {31'd0, ok}, 32'd1);
        check({tg, " frame count"}, nfr - base, nexp);
        check({tg, " R1 frame0 bytes"}, fr_data[base % 8], e0);
        check({tg, " frame0 length"}, fr_len[base % 8], (op == 2'd3) ? 4 : 3);
        if (nexp == 2) begin
            check({tg, " R1 frame1 bytes"}, fr_data[(base + 1) % 8], e1);
            check({tg, " frame1 length"}, fr_len[(base + 1) % 8], 3);
        end
        if (op == 2'd2) exp_rdata = rs[23:8];
        if (op == 2'd3) exp_rdata = rs[15:0];
        check({tg, " R10 rdata at done"}, {16'd0, rdata}, {16'd0, exp_rdata});
        check("R10 busy low at done", {31'd0, busy}, 32'd0);
        @(negedge clk);
        check("R10 done one cycle", {31'd0, done}, 32'd0);
    endtask

    initial begin
        repeat (150000) @(posedge clk);
        fails++;
        $display("FAIL watchdog actual=timeout expected=finish");
        $display("[TB] %0d tests run, %0d failed", tests, fails);
        $finish;
    end

    initial begin
        repeat (4) @(negedge clk);
        rst = 1'b0;
        @(negedge clk);
        // R11 reset state
        check("R11 cs_n", {31'd0, spi_cs_n}, 32'd1);
        check("R11 sclk", {31'd0, spi_sclk}, 32'd0);
        check("R11 busy", {31'd0, busy}, 32'd0);
        check("R11 done", {31'd0, done}, 32'd0);
        check("R11 rdata", {16'd0, rdata}, 32'd0);

        for (int v = 0; v < NVEC; v++)
            run_cmd(VEC[v][59:58], VEC[v][57:50], VEC[v][49:34],
                    VEC[v][33], VEC[v][32], VEC[v][31:0]);

        // R9: a request while busy is dropped
        begin
            int base, falls;
            bit ok;
            resp = 32'h00BE_EF00;
            base = nfr;
            issue(2'd2, 8'h07, 16'h0000, 1'b0, 1'b1);
            repeat (10) @(negedge clk);
            cmd_op = 2'd3; cmd_valid = 1'b1;
            @(negedge clk);
            cmd_valid = 1'b0;
            wait_done(ok);
            check("R9 busy cmd ignored frames", nfr - base, 2);
            check("R9 rdata from first cmd", {16'd0, rdata}, 32'h0000_BEEF);
            falls = 0;
            for (int i = 0; i < 300; i++) begin
                @(negedge clk);
                if (!spi_cs_n) falls++;
            end
            check("R9 no frame after ignored cmd", falls, 0);
        end

        check("R7 mode0 line violations", mode_viol, 0);
        check("R8 sclk period limit", {31'd0, (min_per * REG_HZ >= SYS_HZ)}, 32'd1);
        check("R3 cs gap >= sclk period", {31'd0, (min_gap >= min_per)}, 32'd1);

        $display("[TB] %0d tests run, %0d failed", tests, fails);
        $finish;
    end

endmodule